// File: doc/BRIEF.md
# Glitch-Filtering Level Interrupt Qualifier

This block sits between a noisy interrupt wire from a storage device and the chip's interrupt controller. The device asks for service by holding its line high. The path in front of the controller, however, reacts to changes in both directions, so a single request can arrive mixed with spurious events caused by the falling edge or by ringing on the board. The block turns this stream into a clean, one-cycle request pulse that the controller can consume directly.

The raw wire first passes through a flop synchronizer. Any change of the synchronized level, rising or falling, starts a qualification. A qualification reads the level on two consecutive clocks. If the two reads agree, the level is taken as settled. If they differ, the block makes another attempt, up to a parameterised number of attempts. A settled high level produces one request pulse. A settled low level, or a run of attempts that never settles, ends the event with no pulse. Changes that occur while a qualification is running are absorbed into it and are not queued. Two saturating counters report how many events were forwarded and how many were discarded.

Top module: `irq_qualifier`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `irq_pulse` is 0 and both `fwd_count` and `drop_count` are 0.
- R2: `pin_raw` passes through a two-flop synchronizer (SYNC_STAGES=2). If `pin_raw` is first sampled high at clock edge k after a settled low, `irq_pulse` is 1 from edge k+4 until edge k+5 and is 0 at every other time around that event.
- R3: A change of the synchronized level in either direction starts a qualification.
- R4: One attempt reads the synchronized level on two consecutive clock edges. The qualification ends at the first attempt in which both reads are equal.
- R5: At most MAX_TRIES attempts (default 8) are made for each event. If none of them yields two equal reads, the event is discarded without a pulse and `drop_count` increments.
- R6: If the settled level is 0, the event is discarded without a pulse and `drop_count` increments.
- R7: Only a settled level of 1 produces a request. The request is a single-cycle pulse on `irq_pulse`, and `fwd_count` increments at the same time.
- R8: A level change that occurs while a qualification is in progress starts no further qualification, either at that moment or after the current one ends.
- R9: `fwd_count` counts forwarded events and holds at 2^CNT_W-1 once it reaches that value.
- R10: `drop_count` counts discarded events and holds at 2^CNT_W-1 once it reaches that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Asynchronous interrupt wire from the device |
| irq_pulse | output | 1 | Qualified one-cycle request to the interrupt controller |
| fwd_count | output | CNT_W | Saturating count of forwarded events |
| drop_count | output | CNT_W | Saturating count of discarded events |

## Verification
The main function is driven with clean rising and falling steps, which separate the forward path from the low-level discard path and pin down the exact latency of the pulse. A one-cycle blip exercises edge merging. A sweep of toggling bursts of every length from 0 to 40 cycles, each followed by a settled high or a settled low, probes where the retry budget ends: bursts that settle within the eighth attempt must be forwarded or dropped according to the final level, and longer ones must be dropped. A long series of alternating steps drives both counters into saturation.

// File: rtl/irqq_pkg.sv
package irqq_pkg;

   typedef enum logic [1:0] {
      QS_IDLE  = 2'd0,
      QS_FIRST = 2'd1,
      QS_SECND = 2'd2
   } qual_state_e;

   typedef enum logic [1:0] {
      QR_NONE = 2'd0,
      QR_FWD  = 2'd1,
      QR_DROP = 2'd2
   } qual_result_e;

   localparam int unsigned CNT_FWD  = 0;
   localparam int unsigned CNT_DROP = 1;
   localparam int unsigned CNT_NUM  = 2;

endpackage

// File: rtl/irqq_sync.sv
module irqq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irqq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d_async;
            end
         end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/irqq_edge.sv
module irqq_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic chg
);

   logic lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl;
   end

   assign chg = lvl ^ lvl_d;

   // R3: a level change stays visible for exactly one cycle
   p_chg_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> (lvl == $past(lvl)) || chg);

endmodule

// File: rtl/irqq_qual.sv
module irqq_qual
   import irqq_pkg::*;
#(
   parameter int unsigned MAX_TRIES = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         lvl,
   input  logic         chg,
   output logic         fire,
   output logic         drop
);

   generate
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("irqq_qual: MAX_TRIES must be at least 1");
      end
   endgenerate

   localparam int unsigned TW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
   localparam logic [TW-1:0] LAST_TRY = TW'(MAX_TRIES - 1);

   qual_state_e  st_q, st_d;
   logic [TW-1:0] try_q, try_d;
   logic          first_q, first_d;
   qual_result_e  res;

   always_comb begin
      st_d    = st_q;
      try_d   = try_q;
      first_d = first_q;
      res     = QR_NONE;
      unique case (st_q)
         QS_IDLE: begin
            if (chg) begin
               st_d  = QS_FIRST;
               try_d = '0;
            end
         end
         QS_FIRST: begin
            first_d = lvl;
            st_d    = QS_SECND;
         end
         QS_SECND: begin
            if (lvl == first_q) begin
               res  = lvl ? QR_FWD : QR_DROP;
               st_d = QS_IDLE;
            end else if (try_q == LAST_TRY) begin
               res  = QR_DROP;
               st_d = QS_IDLE;
            end else begin
               try_d = try_q + 1'b1;
               st_d  = QS_FIRST;
            end
         end
         default: st_d = QS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= QS_IDLE;
         try_q   <= '0;
         first_q <= 1'b0;
         fire    <= 1'b0;
         drop    <= 1'b0;
      end else begin
         st_q    <= st_d;
         try_q   <= try_d;
         first_q <= first_d;
         fire    <= (res == QR_FWD);
         drop    <= (res == QR_DROP);
      end
   end

   // R5: the attempt index never passes the budget
   p_try_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      try_q <= LAST_TRY);

   // R7: a request lasts a single cycle
   p_fire_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);

   // R7: a request is only raised after a high read
   p_fire_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> $past(lvl));

   // R6: an event ends in one outcome only
   p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(fire && drop));

   // R8: a change seen while busy does not reopen a sequence next cycle
   p_merge_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == QS_FIRST) |=> (st_q == QS_SECND));

endmodule

// File: rtl/irqq_satcnt.sv
module irqq_satcnt #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [WIDTH-1:0] cnt
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("irqq_satcnt: WIDTH must be at least 1");
      end
   endgenerate

   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
   end

   // R9 and R10: the count holds at its ceiling
   p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == TOP) |=> (cnt == TOP));

   // R10: a counted event adds exactly one below the ceiling
   p_step_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/irq_qualifier.sv
module irq_qualifier
   import irqq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MAX_TRIES   = 8,
   parameter int unsigned CNT_W       = 8,
   parameter bit          COUNT_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_raw,
   output logic             irq_pulse,
   output logic [CNT_W-1:0] fwd_count,
   output logic [CNT_W-1:0] drop_count
);

   logic lvl_s;
   logic chg_s;
   logic fire_s;
   logic drop_s;
   logic [CNT_NUM-1:0]   inc_v;
   logic [CNT_W-1:0]     cnt_v [CNT_NUM];

   irqq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_raw),
      .q_sync  (lvl_s)
   );

   irqq_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl_s),
      .chg   (chg_s)
   );

   irqq_qual #(.MAX_TRIES(MAX_TRIES)) u_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl_s),
      .chg   (chg_s),
      .fire  (fire_s),
      .drop  (drop_s)
   );

   assign inc_v[CNT_FWD]  = fire_s;
   assign inc_v[CNT_DROP] = drop_s;

   generate
      for (genvar c = 0; c < CNT_NUM; c++) begin : g_cnt
         if (COUNT_EN) begin : g_on
            irqq_satcnt #(.WIDTH(CNT_W)) u_cnt (
               .clk   (clk),
               .rst_n (rst_n),
               .inc   (inc_v[c]),
               .cnt   (cnt_v[c])
            );
         end else begin : g_off
            assign cnt_v[c] = '0;
         end
      end
   endgenerate

   assign irq_pulse  = fire_s;
   assign fwd_count  = cnt_v[CNT_FWD];
   assign drop_count = cnt_v[CNT_DROP];

   // R1: quiet output on the first cycle out of reset
   p_reset_quiet_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!irq_pulse && fwd_count == '0 && drop_count == '0));

   // R2: no request without a high level on the wire in the recent past
   p_needs_wire_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> $past(pin_raw, 4) || $past(pin_raw, 3));

endmodule

// File: tb/sim_irq_qualifier.sv
module sim_irq_qualifier;

   localparam int CLK_PERIOD = 10;
   localparam int MAXT       = 8;
   localparam int CW         = 8;
   localparam int CTOP       = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pin_raw = 1'b0;
   logic          irq_pulse;
   logic [CW-1:0] fwd_count;
   logic [CW-1:0] drop_count;

   int n_checks = 0;
   int n_errors = 0;
   int trace_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_qualifier #(.SYNC_STAGES(2), .MAX_TRIES(MAXT), .CNT_W(CW), .COUNT_EN(1'b1)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_raw    (pin_raw),
      .irq_pulse  (irq_pulse),
      .fwd_count  (fwd_count),
      .drop_count (drop_count)
   );

   // Behavioural expectation built from R2..R10
   logic m_s1, m_s2, m_sd, m_a, m_pulse;
   int   m_st, m_try, m_fwd, m_drop;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= 0; m_s2 <= 0; m_sd <= 0; m_a <= 0; m_pulse <= 0;
         m_st <= 0; m_try <= 0; m_fwd <= 0; m_drop <= 0;
      end else begin
         m_s1 <= pin_raw; m_s2 <= m_s1; m_sd <= m_s2;
         m_pulse <= 1'b0;
         case (m_st)
            0: if (m_s2 != m_sd) begin m_st <= 1; m_try <= 0; end
            1: begin m_a <= m_s2; m_st <= 2; end
            default: begin
               if (m_s2 == m_a) begin
                  if (m_s2) begin
                     m_pulse <= 1'b1;
                     if (m_fwd < CTOP) m_fwd <= m_fwd + 1;
                  end else if (m_drop < CTOP) m_drop <= m_drop + 1;
                  m_st <= 0;
               end else if (m_try == MAXT - 1) begin
                  if (m_drop < CTOP) m_drop <= m_drop + 1;
                  m_st <= 0;
               end else begin
                  m_try <= m_try + 1;
                  m_st <= 1;
               end
            end
         endcase
      end
   end

   always @(negedge clk) if (rst_n && irq_pulse !== m_pulse) trace_err++;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic check_counts(input string req);
      check(fwd_count == CW'(m_fwd), {req, " fwd_count"}, fwd_count, m_fwd);
      check(drop_count == CW'(m_drop), {req, " drop_count"}, drop_count, m_drop);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      int f0, d0, first, cnt;
      // R1 reset state
      idle(3);
      check(irq_pulse == 0 && fwd_count == 0 && drop_count == 0, "R1 during reset", irq_pulse, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(irq_pulse == 0 && fwd_count == 0 && drop_count == 0, "R1 after release", fwd_count + drop_count, 0);
      idle(5);

      // R2 / R7 clean rise: pulse on the 5th negedge after drive, width one
      f0 = fwd_count;
      pin_raw = 1'b1;
      first = 0; cnt = 0;
      for (int i = 1; i <= 12; i++) begin
         @(negedge clk);
         if (irq_pulse) begin cnt++; if (first == 0) first = i; end
      end
      check(first == 5, "R2 latency", first, 5);
      check(cnt == 1, "R7 single pulse", cnt, 1);
      check(fwd_count == CW'(f0 + 1), "R7 fwd increment", fwd_count, f0 + 1);

      // R3 / R6 clean fall is qualified and dropped
      d0 = drop_count; cnt = 0;
      pin_raw = 1'b0;
      for (int i = 0; i < 12; i++) begin @(negedge clk); if (irq_pulse) cnt++; end
      check(cnt == 0, "R6 no pulse on low", cnt, 0);
      check(drop_count == CW'(d0 + 1), "R3 fall starts a sequence", drop_count, d0 + 1);

      // R8 one-cycle blip: both edges merge into one dropped event
      d0 = drop_count; f0 = fwd_count;
      pin_raw = 1'b1; @(negedge clk); pin_raw = 1'b0;
      idle(20);
      check(drop_count == CW'(d0 + 1), "R8 merged drop", drop_count, d0 + 1);
      check(fwd_count == CW'(f0), "R8 no forward", fwd_count, f0);

      // R5 endless toggling ending low: nothing forwarded
      f0 = fwd_count;
      for (int i = 0; i < 60; i++) begin pin_raw = ~pin_raw; @(negedge clk); end
      pin_raw = 1'b0;
      idle(30);
      check(fwd_count == CW'(f0), "R5 noise never forwards", fwd_count, f0);
      check(drop_count >= CW'(d0 + 3), "R5 noise dropped", drop_count, d0 + 3);
      check_counts("R5 noise");

      // R4 / R5 / R6 sweep of burst lengths with each final level
      for (int lvl = 0; lvl < 2; lvl++) begin
         for (int n = 0; n <= 40; n++) begin
            pin_raw = 1'b0; idle(25);
            if (lvl == 1) begin pin_raw = 1'b1; idle(25); pin_raw = 1'b0; idle(25); end
            for (int i = 0; i < n; i++) begin pin_raw = ~pin_raw; @(negedge clk); end
            pin_raw = lvl[0];
            idle(30);
         end
         check_counts(lvl ? "R4 sweep high" : "R6 sweep low");
      end
      check(trace_err == 0, "R4 R5 pulse trace", trace_err, 0);

      // R9 / R10 saturation
      for (int i = 0; i < 270; i++) begin
         pin_raw = 1'b1; idle(10);
         pin_raw = 1'b0; idle(10);
      end
      idle(10);
      check(fwd_count == CW'(CTOP), "R9 fwd saturates", fwd_count, CTOP);
      check(drop_count == CW'(CTOP), "R10 drop saturates", drop_count, CTOP);
      check(trace_err == 0, "R7 pulse trace final", trace_err, 0);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule